// File: doc/BRIEF.md
# Pulse Train Timing Generator

This block produces the on/off gating pattern for a pulsed load from a single fast reference clock. A prescaler turns the clock into a slow timebase tick (one millisecond at 10 MHz with the default divider). A start request launches a train: a programmed number of pulses, each lasting a programmed number of ticks, separated by a programmed number of idle ticks. Pulses begin only on tick boundaries, so no pulse is ever cut short. The train ends when the last pulse falls. There is no trailing gap.

A repeat scheduler runs as a small binary state counter. It advances once every `SCHED_DIV` ticks. At a programmable clear state it wraps back to zero and fires a train-start strobe, so the interval between trains is the clear value times the scheduler period. The scheduler also emits a one-cycle measurement strobe when it enters state 1. It emits a one-cycle readout strobe when it enters its last state (clear − 1).

All timing values are latched when a train or scheduler period begins. The lamp-enable and busy outputs are registered. The lamp-enable output also gates the external current servo.

Train FSM states: IDLE (waiting), ARM (accepted, waiting for the next tick), ON (lamp lit), OFF (gap between pulses). Transitions:
- IDLE→ARM on a start request.
- ARM→ON on a tick.
- ON→OFF on the final tick of the on phase, when more pulses remain.
- ON→IDLE on the final tick of the on phase of the last pulse.
- OFF→ON on the final tick of the gap.

Top module: `pulse_train_gen`

## Requirements
- R1: While reset is held, and after reset until a start arrives, `lamp_o`, `busy_o` and all three strobes are 0.
- R2: Each pulse keeps `lamp_o` high for exactly on × TICK_DIV clock cycles, where on is the latched on-time in ticks.
- R3: Between consecutive pulses of a train, `lamp_o` is low for exactly off × TICK_DIV cycles.
- R4: A train holds exactly count pulses. `busy_o` is high from the cycle after the start is accepted, and it falls in the same cycle as the last pulse falls.
- R5: The first pulse rises between 1 and TICK_DIV cycles after `busy_o` rises. Every pulse rise falls on a timebase tick boundary, so all rise times are congruent modulo TICK_DIV.
- R6: A start request, from the port or the scheduler, that arrives while `busy_o` is high is ignored. The train keeps its pulse count, and no second train follows.
- R7: The on, off and count values are latched when a start is accepted. Changes to these values during a train have no effect on that train.
- R8: With `auto_i` high, `train_stb_o` pulses for one cycle every clear × SCHED_DIV × TICK_DIV cycles. Each such pulse launches a train, and `busy_o` rises on the following cycle.
- R9: After each `train_stb_o`, exactly one `meas_stb_o` follows after SCHED_DIV × TICK_DIV cycles. Exactly one `read_stb_o` follows after (clear − 1) × SCHED_DIV × TICK_DIV cycles. No two strobes are ever high together.
- R10: The clear value (valid range 3 to 2^ST_W − 1) is latched at each wrap, and continuously while `auto_i` is low. A change made during a scheduler period takes effect from the next period.
- R11: While `auto_i` is low, no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Train start request (one or more cycles) |
| auto_i | input | 1 | Enables the repeat scheduler |
| cfg_on_i | input | ON_W | On time per pulse, in ticks (≥ 1) |
| cfg_off_i | input | OFF_W | Gap between pulses, in ticks (≥ 1) |
| cfg_count_i | input | CNT_W | Pulses per train (≥ 1) |
| cfg_clear_i | input | ST_W | Scheduler clear state (3 to 2^ST_W − 1) |
| lamp_o | output | 1 | Registered lamp enable / servo gate |
| busy_o | output | 1 | Train in progress |
| train_stb_o | output | 1 | One-cycle strobe at scheduler wrap |
| meas_stb_o | output | 1 | One-cycle strobe on entering scheduler state 1 |
| read_stb_o | output | 1 | One-cycle strobe on entering the last scheduler state |

## Verification
The embedded properties assume that the on, off and count inputs are never zero. They also assume the clear input stays within 3 to 2^ST_W − 1 whenever it can be latched. Outside those ranges, the phase-counter, pulse-counter and scheduler-state bounds have no meaning. The bench programs only values inside these ranges. It sweeps on, off and count over a small grid, with a short prescaler and scheduler divider. Every out-of-band stimulus it applies is timing-related only: starts and configuration changes injected mid-train, and clear changes injected mid-period.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'd0,
        TR_ARM  = 2'd1,
        TR_ON   = 2'd2,
        TR_OFF  = 2'd3
    } tr_state_e;

    typedef enum logic {
        SC_HOLD = 1'b0,
        SC_RUN  = 1'b1
    } sc_state_e;

endpackage

// File: rtl/ptg_tick.sv
module ptg_tick #(
    parameter int DIV = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    assert_prescale_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/ptg_sched.sv
module ptg_sched
    import ptg_pkg::*;
#(
    parameter int SDIV      = 2000,
    parameter int ST_W      = 4,
    parameter int DEF_CLEAR = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            auto_i,
    input  logic [ST_W-1:0] cfg_clear_i,
    output logic            train_o,
    output logic            meas_o,
    output logic            read_o
);
    localparam int SW = (SDIV > 1) ? $clog2(SDIV) : 1;
    localparam logic [SW-1:0] SLAST = SW'(SDIV - 1);

    sc_state_e       mode_q, mode_n;
    logic [SW-1:0]   scnt_q;
    logic [ST_W-1:0] st_q;
    logic [ST_W-1:0] clr_q;
    logic            stick, wrap_e;
    logic            train_q, meas_q, read_q;

    assign stick  = (mode_q == SC_RUN) && tick_i && (scnt_q == SLAST);
    assign wrap_e = stick && (st_q == clr_q - ST_W'(1));

    // mode state register
    always_comb begin
        mode_n = mode_q;
        unique case (mode_q)
            SC_HOLD: if (auto_i)  mode_n = SC_RUN;
            SC_RUN:  if (!auto_i) mode_n = SC_HOLD;
            default: mode_n = SC_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= SC_HOLD;
        else        mode_q <= mode_n;
    end

    // scheduler counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scnt_q <= '0;
            st_q   <= '0;
            clr_q  <= ST_W'(DEF_CLEAR);
        end else if (!auto_i || mode_q == SC_HOLD) begin
            scnt_q <= '0;
            st_q   <= '0;
            clr_q  <= cfg_clear_i;
        end else if (tick_i) begin
            scnt_q <= (scnt_q == SLAST) ? '0 : scnt_q + 1'b1;
            if (stick) begin
                if (wrap_e) begin
                    st_q  <= '0;
                    clr_q <= cfg_clear_i;
                end else begin
                    st_q <= st_q + 1'b1;
                end
            end
        end
    end

    // output strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            train_q <= 1'b0;
            meas_q  <= 1'b0;
            read_q  <= 1'b0;
        end else begin
            train_q <= auto_i && wrap_e;
            meas_q  <= auto_i && stick && !wrap_e && (st_q == '0);
            read_q  <= auto_i && stick && !wrap_e && (st_q == clr_q - ST_W'(2));
        end
    end

    assign train_o = train_q;
    assign meas_o  = meas_q;
    assign read_o  = read_q;

    assert_state_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SC_RUN) |-> (st_q < clr_q));

    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({train_q, meas_q, read_q}));

    assert_clear_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(auto_i) && auto_i && (mode_q == SC_RUN) && !$past(wrap_e)) |-> $stable(clr_q));

    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_i |=> !(train_q || meas_q || read_q));

endmodule

// File: rtl/ptg_train.sv
module ptg_train
    import ptg_pkg::*;
#(
    parameter int ON_W    = 8,
    parameter int OFF_W   = 8,
    parameter int CNT_W   = 5,
    parameter int DEF_ON  = 10,
    parameter int DEF_OFF = 90,
    parameter int DEF_CNT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic [ON_W-1:0]  cfg_on_i,
    input  logic [OFF_W-1:0] cfg_off_i,
    input  logic [CNT_W-1:0] cfg_cnt_i,
    output logic             lamp_o,
    output logic             busy_o
);
    localparam int TW = (ON_W > OFF_W) ? ON_W : OFF_W;

    tr_state_e        state_q, state_n;
    logic [TW-1:0]    tcnt_q;
    logic [CNT_W-1:0] pnum_q;
    logic [ON_W-1:0]  on_q;
    logic [OFF_W-1:0] off_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TW-1:0]    on_ext, off_ext;
    logic             on_end, off_end, pulse_last, accept;
    logic             lamp_q, busy_q;

    assign on_ext     = TW'(on_q);
    assign off_ext    = TW'(off_q);
    assign on_end     = (tcnt_q == on_ext - TW'(1));
    assign off_end    = (tcnt_q == off_ext - TW'(1));
    assign pulse_last = (pnum_q == cnt_q - CNT_W'(1));
    assign accept     = (state_q == TR_IDLE) && start_i;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            TR_IDLE: if (start_i)           state_n = TR_ARM;
            TR_ARM:  if (tick_i)            state_n = TR_ON;
            TR_ON:   if (tick_i && on_end)  state_n = pulse_last ? TR_IDLE : TR_OFF;
            TR_OFF:  if (tick_i && off_end) state_n = TR_ON;
            default:                        state_n = TR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TR_IDLE;
        else        state_q <= state_n;
    end

    // phase and pulse counters, configuration latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            pnum_q <= '0;
            on_q   <= ON_W'(DEF_ON);
            off_q  <= OFF_W'(DEF_OFF);
            cnt_q  <= CNT_W'(DEF_CNT);
        end else begin
            if (accept) begin
                on_q   <= cfg_on_i;
                off_q  <= cfg_off_i;
                cnt_q  <= cfg_cnt_i;
                tcnt_q <= '0;
                pnum_q <= '0;
            end
            if (tick_i && state_q == TR_ON) begin
                if (on_end) begin
                    tcnt_q <= '0;
                    pnum_q <= pnum_q + 1'b1;
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
            end
            if (tick_i && state_q == TR_OFF) begin
                tcnt_q <= off_end ? '0 : tcnt_q + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lamp_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            lamp_q <= (state_n == TR_ON);
            busy_q <= (state_n != TR_IDLE);
        end
    end

    assign lamp_o = lamp_q;
    assign busy_o = busy_q;

    assert_on_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TR_ON) |-> (tcnt_q < on_ext));

    assert_off_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TR_OFF) |-> (tcnt_q < off_ext));

    assert_lamp_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_q |-> busy_q);

    assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TR_IDLE) |-> (pnum_q < cnt_q));

    assert_rise_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lamp_q) |-> $past(tick_i));

    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TR_IDLE) |=> ($stable(on_q) && $stable(off_q) && $stable(cnt_q)));

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
    parameter int TICK_DIV  = 10000,
    parameter int SCHED_DIV = 2000,
    parameter int ON_W      = 8,
    parameter int OFF_W     = 8,
    parameter int CNT_W     = 5,
    parameter int ST_W      = 4,
    parameter int DEF_ON    = 10,
    parameter int DEF_OFF   = 90,
    parameter int DEF_CNT   = 10,
    parameter int DEF_CLEAR = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             auto_i,
    input  logic [ON_W-1:0]  cfg_on_i,
    input  logic [OFF_W-1:0] cfg_off_i,
    input  logic [CNT_W-1:0] cfg_count_i,
    input  logic [ST_W-1:0]  cfg_clear_i,
    output logic             lamp_o,
    output logic             busy_o,
    output logic             train_stb_o,
    output logic             meas_stb_o,
    output logic             read_stb_o
);
    logic tick;
    logic sched_train;
    logic start_any;

    ptg_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ptg_sched #(
        .SDIV      (SCHED_DIV),
        .ST_W      (ST_W),
        .DEF_CLEAR (DEF_CLEAR)
    ) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .auto_i      (auto_i),
        .cfg_clear_i (cfg_clear_i),
        .train_o     (sched_train),
        .meas_o      (meas_stb_o),
        .read_o      (read_stb_o)
    );

    assign start_any   = start_i | sched_train;
    assign train_stb_o = sched_train;

    ptg_train #(
        .ON_W    (ON_W),
        .OFF_W   (OFF_W),
        .CNT_W   (CNT_W),
        .DEF_ON  (DEF_ON),
        .DEF_OFF (DEF_OFF),
        .DEF_CNT (DEF_CNT)
    ) u_train (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .start_i   (start_any),
        .cfg_on_i  (cfg_on_i),
        .cfg_off_i (cfg_off_i),
        .cfg_cnt_i (cfg_count_i),
        .lamp_o    (lamp_o),
        .busy_o    (busy_o)
    );

endmodule

// File: tb/sim_pulse_train_gen.sv
module sim_pulse_train_gen;
    localparam int TD = 3;
    localparam int SD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       auto_i = 1'b0;
    logic [7:0] cfg_on_i = 8'd1;
    logic [7:0] cfg_off_i = 8'd1;
    logic [4:0] cfg_count_i = 5'd1;
    logic [3:0] cfg_clear_i = 4'd4;
    logic       lamp_o, busy_o, train_stb_o, meas_stb_o, read_stb_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rise_ref = -1;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulse_train_gen #(.TICK_DIV(TD), .SCHED_DIV(SD)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_i(auto_i),
        .cfg_on_i(cfg_on_i), .cfg_off_i(cfg_off_i), .cfg_count_i(cfg_count_i),
        .cfg_clear_i(cfg_clear_i), .lamp_o(lamp_o), .busy_o(busy_o),
        .train_stb_o(train_stb_o), .meas_stb_o(meas_stb_o), .read_stb_o(read_stb_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic run_train(input int on, input int off, input int cnt, input bit poke);
        int lead, hi, lo, pulses, bad;
        cfg_on_i = 8'(on); cfg_off_i = 8'(off); cfg_count_i = 5'(cnt);
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        check(busy_o === 1'b1, "R4", int'(busy_o), 1);
        lead = 0;
        while (!lamp_o && lead < 50) begin lead++; step(); end
        check(lead >= 1 && lead <= TD, "R5", lead, TD);
        if (rise_ref < 0) rise_ref = cyc % TD;
        check(cyc % TD == rise_ref, "R5", cyc % TD, rise_ref);
        pulses = 0; bad = 0;
        forever begin
            hi = 0;
            while (lamp_o && hi < 200) begin
                hi++;
                if (poke && pulses == 0 && hi == 1) begin
                    start_i = 1'b1;
                    cfg_on_i = 8'd7; cfg_off_i = 8'd6; cfg_count_i = 5'd9;
                end else begin
                    start_i = 1'b0;
                end
                step();
            end
            start_i = 1'b0;
            pulses++;
            if (hi != on * TD) bad++;
            check(hi == on * TD, poke ? "R7" : "R2", hi, on * TD);
            if (!busy_o) break;
            lo = 0;
            while (!lamp_o && busy_o && lo < 200) begin lo++; step(); end
            if (lo != off * TD) bad++;
            check(lo == off * TD, poke ? "R7" : "R3", lo, off * TD);
            if (!busy_o || pulses > 40) break;
        end
        check(pulses == cnt, poke ? "R6" : "R4", pulses, cnt);
        if (poke) check(bad == 0, "R7", bad, 0);
        repeat (2 * TD + 2) begin
            step();
            check(!busy_o && !lamp_o, "R6", int'(busy_o), 0);
        end
    endtask

    task automatic sched_period(input int clr);
        int t0, tm, tr, nm, nr, guard;
        t0 = cyc; nm = 0; nr = 0; tm = -1; tr = -1; guard = 0;
        step();
        check(busy_o === 1'b1, "R8", int'(busy_o), 1);
        while (!train_stb_o && guard < 2000) begin
            if (meas_stb_o) begin nm++; tm = cyc; end
            if (read_stb_o) begin nr++; tr = cyc; end
            check($countones({train_stb_o, meas_stb_o, read_stb_o}) <= 1, "R9", 0, 0);
            guard++;
            step();
        end
        check(cyc - t0 == clr * SD * TD, "R10", cyc - t0, clr * SD * TD);
        check(nm == 1 && tm - t0 == SD * TD, "R9", tm - t0, SD * TD);
        check(nr == 1 && tr - t0 == (clr - 1) * SD * TD, "R9", tr - t0, (clr - 1) * SD * TD);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        int guard;
        repeat (4) begin
            step();
            check(!lamp_o && !busy_o && !train_stb_o && !meas_stb_o && !read_stb_o, "R1", int'(lamp_o), 0);
        end
        rst_n = 1'b1;
        repeat (6) begin
            step();
            check(!lamp_o && !busy_o && !train_stb_o && !meas_stb_o && !read_stb_o, "R1", int'(busy_o), 0);
        end
        for (int on = 1; on <= 3; on++)
            for (int off = 1; off <= 3; off++)
                for (int cnt = 1; cnt <= 3; cnt++) begin
                    run_train(on, off, cnt, 1'b0);
                    step();
                end
        run_train(2, 1, 3, 1'b1);
        step(); step();
        run_train(1, 2, 2, 1'b1);

        cfg_on_i = 8'd1; cfg_off_i = 8'd1; cfg_count_i = 5'd1; cfg_clear_i = 4'd4;
        step();
        auto_i = 1'b1;
        guard = 0;
        while (!train_stb_o && guard < 2000) begin guard++; step(); end
        check(train_stb_o === 1'b1, "R8", int'(train_stb_o), 1);
        sched_period(4);
        cfg_clear_i = 4'd6;
        sched_period(4);
        sched_period(6);
        auto_i = 1'b0;
        step();
        repeat (2 * 6 * SD * TD) begin
            step();
            check(!train_stb_o && !meas_stb_o && !read_stb_o, "R11", int'(train_stb_o), 0);
        end
        summary();
        $finish;
    end

endmodule